// File: doc/BRIEF.md
# BT.656 Byte Stream Formatter

This block turns a 4:2:2 component pixel stream into a single 8-bit byte stream with chroma and luma interleaved as Cb, Y, Cr, Y. Each clock the upstream stage presents one pixel: luma, both chroma components, a line-active qualifier, a sample-valid qualifier, and the field and vertical-blank flags. The formatter picks one component per clock. The choice follows a phase that restarts at the first clock of every active or blank run.

In embedded-sync mode the block writes timing reference words into the blanking interval: FF 00 00 XY. It writes the end-of-active word directly after the last active sample and the start-of-active word directly before the first. To place the start word ahead of the line, the stream passes through a four-stage delay, so the upcoming line is visible four clocks early.

Blank positions carry programmable fill codes. An active position whose sample is flagged invalid, such as a sample dropped by an upstream scaler, carries a programmable marker code. Pixel data is clamped to a selectable legal range, so it never takes the reserved values 0x00 and 0xFF. An optional alternate code set clears the top bit of the XY word on vertical-blank lines, which tags those lines as VBI lines.

Top module: `fmt656_out`

## Requirements
- R1: While `rst` is high, `out_byte` is 0x00. The first stream position after reset is a blank position with fill phase 0.
- R2: The phase of a stream position counts clocks from the start of its active or blank run, modulo 4. An active, valid sample outputs Cb at phase 0, Y at phase 1, Cr at phase 2 and Y at phase 3.
- R3: With `cfg_narrow` = 0, every data component is clamped to the range 1..254.
- R4: With `cfg_narrow` = 1, luma is clamped to 16..235 and chroma to 16..240.
- R5: An active position with `in_ok` = 0 outputs `cfg_valid_code` unchanged.
- R6: A blank position that does not carry a timing word outputs a fill code chosen by phase: 0 gives `cfg_fill_u`, 1 and 3 give `cfg_fill_y`, 2 gives `cfg_fill_v`.
- R7: With `cfg_656` = 1, the four blank positions directly after an active run carry FF, 00, 00, XY. XY takes F and V from the last active sample and has H = 1.
- R8: With `cfg_656` = 1, the four blank positions directly before an active run carry FF, 00, 00, XY. XY takes F and V from the first active sample and has H = 0.
- R9: The bits of XY, from bit 7 down to bit 0, are: T, F, V, H, V^H, F^H, F^V, F^V^H, where T = 1 in the standard code set.
- R10: With `cfg_alt_task` = 1, T = 0 on words whose V = 1. The protection bits do not change.
- R11: With `cfg_656` = 0, no timing words are emitted. Those positions carry fill codes as in R6.
- R12: A sample registered at clock edge e appears on `out_byte` after edge e+4. A blank run between active runs must last at least 8 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_act | input | 1 | Line-active qualifier of the current pixel |
| in_ok | input | 1 | Sample-valid qualifier (0 = dropped sample) |
| in_field | input | 1 | Field flag F |
| in_vblank | input | 1 | Vertical-blank flag V |
| in_y | input | 8 | Luma |
| in_cb | input | 8 | Blue-difference chroma |
| in_cr | input | 8 | Red-difference chroma |
| cfg_656 | input | 1 | 1 enables embedded timing words |
| cfg_narrow | input | 1 | 1 selects the 16..235/240 range, 0 selects 1..254 |
| cfg_alt_task | input | 1 | 1 clears T on vertical-blank timing words |
| cfg_fill_y | input | 8 | Luma fill code for blank positions |
| cfg_fill_u | input | 8 | Cb fill code for blank positions |
| cfg_fill_v | input | 8 | Cr fill code for blank positions |
| cfg_valid_code | input | 8 | Marker code for invalid active samples |
| out_byte | output | 8 | Formatted byte stream |

## Verification
The bench drives the input for stream position q+4 in the clock before edge q. Every output byte is therefore due right after edge q and belongs to position q. This fixed alignment allows the start-of-active word, which is decided four clocks before its line arrives, to be compared against the same reference array as the data.

The bench samples `out_byte` at the falling edge after each rising edge. It computes the expected byte for that position only from the run boundaries, the phase and the configuration. The reset value is checked at a falling edge while reset is held.

// File: rtl/fmt656_pkg.sv
package fmt656_pkg;

    localparam int PIX_W   = 8;
    localparam int TRS_LEN = 4;
    localparam int RL_W    = $clog2(TRS_LEN) + 1;

    typedef struct packed {
        logic act;
        logic fld;
        logic vbl;
    } tim_t;

    typedef struct packed {
        logic [PIX_W-1:0] y;
        logic [PIX_W-1:0] cb;
        logic [PIX_W-1:0] cr;
    } pix_t;

    typedef struct packed {
        tim_t t;
        logic ok;
        pix_t p;
    } smp_t;

    typedef enum logic [2:0] {
        W_DATA,
        W_VALID,
        W_FILL,
        W_EAV,
        W_SAV
    } wkind_t;

    typedef struct packed {
        wkind_t      kind;
        logic [1:0]  idx;
        logic        fld;
        logic        vbl;
    } wsel_t;

    function automatic logic [PIX_W-1:0] trs_xy(input logic f, input logic v,
                                                input logic h, input logic tagb);
        return {~tagb, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    function automatic logic [PIX_W-1:0] lim_lo(input logic narrow);
        return narrow ? PIX_W'(16) : PIX_W'(1);
    endfunction

    function automatic logic [PIX_W-1:0] lim_hi(input logic narrow, input logic luma);
        if (!narrow) return PIX_W'(254);
        return luma ? PIX_W'(235) : PIX_W'(240);
    endfunction

    function automatic logic [PIX_W-1:0] clamp_pix(input logic [PIX_W-1:0] x,
                                                   input logic [PIX_W-1:0] lo,
                                                   input logic [PIX_W-1:0] hi);
        if (x < lo) return lo;
        if (x > hi) return hi;
        return x;
    endfunction

endpackage

// File: rtl/smp_delay.sv
module smp_delay
    import fmt656_pkg::*;
#(
    parameter int DEPTH = TRS_LEN
) (
    input  logic                  clk,
    input  logic                  rst,
    input  smp_t                  din,
    output tim_t [DEPTH-1:0]      tim_taps,
    output logic                  last_ok,
    output pix_t                  last_pix
);

    smp_t stage [DEPTH];

    genvar i;
    generate
        for (i = 0; i < DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) stage[i] <= '0;
                    else     stage[i] <= din;
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (rst) stage[i] <= '0;
                    else     stage[i] <= stage[i-1];
                end
            end
            assign tim_taps[i] = stage[i].t;
        end
    endgenerate

    assign last_ok  = stage[DEPTH-1].ok;
    assign last_pix = stage[DEPTH-1].p;

endmodule

// File: rtl/trs_seq.sv
module trs_seq
    import fmt656_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en656,
    input  tim_t                  live,
    input  tim_t [TRS_LEN-1:0]    taps,
    input  logic                  cur_ok,
    output wsel_t                 sel,
    output logic [1:0]            phase
);

    tim_t            cur;
    logic [1:0]      ph_q, ph_eff;
    logic [RL_W-1:0] rl_q, rl_eff;
    logic            last_act, seen_act, last_f, last_v;
    logic            new_run, eav_on, sav_hit;
    logic [1:0]      sav_idx;
    tim_t            sav_src;

    assign cur     = taps[TRS_LEN-1];
    assign new_run = (cur.act != last_act);
    assign ph_eff  = new_run ? 2'd0 : ph_q;
    assign rl_eff  = new_run ? '0 : rl_q;
    assign eav_on  = en656 && !cur.act && seen_act && (rl_eff < RL_W'(TRS_LEN));
    assign phase   = ph_eff;

    always_comb begin
        sav_hit = 1'b0;
        sav_idx = 2'd0;
        sav_src = '0;
        if (live.act) begin
            sav_hit = 1'b1;
            sav_src = live;
        end
        for (int j = 0; j < TRS_LEN - 1; j++) begin
            if (taps[j].act) begin
                sav_hit = 1'b1;
                sav_idx = 2'(j + 1);
                sav_src = taps[j];
            end
        end
    end

    always_comb begin
        sel = '{kind: W_FILL, idx: 2'd0, fld: 1'b0, vbl: 1'b0};
        if (cur.act) begin
            sel.kind = cur_ok ? W_DATA : W_VALID;
        end else if (eav_on) begin
            sel.kind = W_EAV;
            sel.idx  = rl_eff[1:0];
            sel.fld  = last_f;
            sel.vbl  = last_v;
        end else if (en656 && sav_hit) begin
            sel.kind = W_SAV;
            sel.idx  = sav_idx;
            sel.fld  = sav_src.fld;
            sel.vbl  = sav_src.vbl;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q     <= 2'd0;
            rl_q     <= '0;
            last_act <= 1'b0;
            seen_act <= 1'b0;
            last_f   <= 1'b0;
            last_v   <= 1'b0;
        end else begin
            ph_q     <= ph_eff + 2'd1;
            rl_q     <= (rl_eff < RL_W'(TRS_LEN)) ? rl_eff + RL_W'(1) : rl_eff;
            last_act <= cur.act;
            if (cur.act) begin
                seen_act <= 1'b1;
                last_f   <= cur.fld;
                last_v   <= cur.vbl;
            end
        end
    end

endmodule

// File: rtl/word_mux.sv
module word_mux
    import fmt656_pkg::*;
(
    input  wsel_t             sel,
    input  logic [1:0]        phase,
    input  pix_t              pix,
    input  logic              narrow,
    input  logic              alt_task,
    input  logic [PIX_W-1:0]  fill_y,
    input  logic [PIX_W-1:0]  fill_u,
    input  logic [PIX_W-1:0]  fill_v,
    input  logic [PIX_W-1:0]  valid_code,
    output logic [PIX_W-1:0]  word
);

    logic             luma;
    logic [PIX_W-1:0] comp, fill, code;

    assign luma = phase[0];
    assign comp = luma ? pix.y : (phase[1] ? pix.cr : pix.cb);
    assign fill = luma ? fill_y : (phase[1] ? fill_v : fill_u);

    always_comb begin
        case (sel.idx)
            2'd0:    code = '1;
            2'd3:    code = trs_xy(sel.fld, sel.vbl, sel.kind == W_EAV,
                               alt_task && sel.vbl);
            default: code = '0;
        endcase
    end

    always_comb begin
        case (sel.kind)
            W_DATA:  word = clamp_pix(comp, lim_lo(narrow), lim_hi(narrow, luma));
            W_VALID: word = valid_code;
            W_EAV,
            W_SAV:   word = code;
            default: word = fill;
        endcase
    end

endmodule

// File: rtl/fmt656_out.sv
module fmt656_out
    import fmt656_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_act,
    input  logic              in_ok,
    input  logic              in_field,
    input  logic              in_vblank,
    input  logic [7:0]        in_y,
    input  logic [7:0]        in_cb,
    input  logic [7:0]        in_cr,
    input  logic              cfg_656,
    input  logic              cfg_narrow,
    input  logic              cfg_alt_task,
    input  logic [7:0]        cfg_fill_y,
    input  logic [7:0]        cfg_fill_u,
    input  logic [7:0]        cfg_fill_v,
    input  logic [7:0]        cfg_valid_code,
    output logic [7:0]        out_byte
);

    smp_t                live;
    tim_t [TRS_LEN-1:0]  tim_taps;
    logic                last_ok;
    pix_t                last_pix;
    wsel_t               sel;
    logic [1:0]          phase;
    logic [PIX_W-1:0]    word;

    assign live = '{t: '{act: in_act, fld: in_field, vbl: in_vblank},
                    ok: in_ok,
                    p: '{y: in_y, cb: in_cb, cr: in_cr}};

    smp_delay #(.DEPTH(TRS_LEN)) u_dly (
        .clk      (clk),
        .rst      (rst),
        .din      (live),
        .tim_taps (tim_taps),
        .last_ok  (last_ok),
        .last_pix (last_pix)
    );

    trs_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .en656  (cfg_656),
        .live   (live.t),
        .taps   (tim_taps),
        .cur_ok (last_ok),
        .sel    (sel),
        .phase  (phase)
    );

    word_mux u_mux (
        .sel        (sel),
        .phase      (phase),
        .pix        (last_pix),
        .narrow     (cfg_narrow),
        .alt_task   (cfg_alt_task),
        .fill_y     (cfg_fill_y),
        .fill_u     (cfg_fill_u),
        .fill_v     (cfg_fill_v),
        .valid_code (cfg_valid_code),
        .word       (word)
    );

    always_ff @(posedge clk) begin
        if (rst) out_byte <= '0;
        else     out_byte <= word;
    end

endmodule

// File: rtl/fmt656_out_chk.sv
module fmt656_out_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_656,
    input logic       cfg_narrow,
    input logic       cfg_alt_task,
    input logic [7:0] cfg_fill_y,
    input logic [7:0] cfg_fill_u,
    input logic [7:0] cfg_fill_v,
    input logic [7:0] cfg_valid_code,
    input logic [7:0] out_byte
);

    logic safe;
    logic mid;
    assign safe = !(cfg_fill_y inside {8'h00, 8'hFF}) && !(cfg_fill_u inside {8'h00, 8'hFF})
               && !(cfg_fill_v inside {8'h00, 8'hFF}) && !(cfg_valid_code inside {8'h00, 8'hFF});
    assign mid  = (cfg_fill_y inside {[8'd16:8'd240]}) && (cfg_fill_u inside {[8'd16:8'd240]})
               && (cfg_fill_v inside {[8'd16:8'd240]}) && (cfg_valid_code inside {[8'd16:8'd240]});

    // R7: the preamble word FF is always followed by 00
    assert_pre_first_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (safe && out_byte == 8'hFF) |=> (out_byte == 8'h00));

    // R8: second preamble zero follows the first
    assert_pre_second_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (safe && $past(out_byte) == 8'hFF && out_byte == 8'h00) |=> (out_byte == 8'h00));

    // R9: protection nibble of the XY word
    assert_xy_protect_R9: assert property (@(posedge clk) disable iff (rst)
        (safe && $past(out_byte, 3) == 8'hFF && $past(out_byte, 2) == 8'h00
              && $past(out_byte, 1) == 8'h00)
        |-> (out_byte[3:0] == {out_byte[5] ^ out_byte[4], out_byte[6] ^ out_byte[4],
                               out_byte[6] ^ out_byte[5], out_byte[6] ^ out_byte[5] ^ out_byte[4]}));

    // R10: task bit of the XY word
    assert_xy_task_R10: assert property (@(posedge clk) disable iff (rst)
        (safe && $past(out_byte, 3) == 8'hFF && $past(out_byte, 2) == 8'h00
              && $past(out_byte, 1) == 8'h00)
        |-> (out_byte[7] == !(cfg_alt_task && out_byte[5])));

    // R11: no preamble without embedded sync
    assert_no_codes_off_R11: assert property (@(posedge clk) disable iff (rst)
        (!cfg_656 && safe) |=> (out_byte != 8'hFF));

    // R4: narrow range holds for every byte when no codes are inserted
    assert_narrow_range_R4: assert property (@(posedge clk) disable iff (rst)
        (!cfg_656 && cfg_narrow && mid) |=> (out_byte inside {[8'd16:8'd240]}));

endmodule

bind fmt656_out fmt656_out_chk u_chk (.*);

// File: tb/fmt656_out_test.sv
module fmt656_out_test;

    localparam int MAXN = 640;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_act = 0, in_ok = 0, in_field = 0, in_vblank = 0;
    logic [7:0] in_y = 0, in_cb = 0, in_cr = 0;
    logic       cfg_656 = 0, cfg_narrow = 0, cfg_alt_task = 0;
    logic [7:0] cfg_fill_y = 8'h10, cfg_fill_u = 8'h80, cfg_fill_v = 8'h80, cfg_valid_code = 8'h20;
    logic [7:0] out_byte;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic       a_act [MAXN];
    logic       a_ok  [MAXN];
    logic       a_f   [MAXN];
    logic       a_v   [MAXN];
    logic [7:0] a_y   [MAXN];
    logic [7:0] a_cb  [MAXN];
    logic [7:0] a_cr  [MAXN];
    int slen;

    always #2.5 clk = ~clk;

    fmt656_out uut (.*);

    function automatic logic [7:0] rnd_byte();
        int r = $urandom % 8;
        if (r == 0) return 8'h00;
        if (r == 1) return 8'hFF;
        if (r == 2) return 8'd8;
        if (r == 3) return 8'd245;
        return 8'($urandom);
    endfunction

    task automatic push(input bit act, input bit f, input bit v);
        a_act[slen] = act;
        a_f[slen]   = act ? f : 1'b0;
        a_v[slen]   = act ? v : 1'b0;
        a_ok[slen]  = act ? (($urandom % 5) != 0) : 1'b0;
        a_y[slen]   = act ? rnd_byte() : 8'h00;
        a_cb[slen]  = act ? rnd_byte() : 8'h00;
        a_cr[slen]  = act ? rnd_byte() : 8'h00;
        slen++;
    endtask

    task automatic build(input int nlines, input bit directed);
        slen = 0;
        for (int i = 0; i < 4 + 8 + int'($urandom % 8); i++) push(0, 0, 0);
        for (int ln = 0; ln < nlines; ln++) begin
            int  alen = (directed && ln == 0) ? 1 : 4 + int'($urandom % 28);
            int  blen = (directed && ln == 0) ? 8 : 8 + int'($urandom % 9);
            bit  f = 1'($urandom);
            bit  v = 1'($urandom);
            for (int i = 0; i < alen; i++) push(1, f, v);
            for (int i = 0; i < blen; i++) push(0, 0, 0);
        end
        for (int i = 0; i < 12; i++) push(0, 0, 0);
    endtask

    function automatic logic [7:0] xy(input bit f, input bit v, input bit h);
        bit t = !(cfg_alt_task && v);
        return {t, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    task automatic calc(input int q, output logic [7:0] e, output string tag);
        int st = q;
        int k;
        int en;
        while (st > 0 && a_act[st-1] == a_act[q]) st--;
        k = q - st;
        if (a_act[q]) begin
            bit luma = (k % 2) == 1;
            logic [7:0] c = luma ? a_y[q] : ((k % 4) == 2 ? a_cr[q] : a_cb[q]);
            int lo = cfg_narrow ? 16 : 1;
            int hi = !cfg_narrow ? 254 : (luma ? 235 : 240);
            if (!a_ok[q]) begin
                e = cfg_valid_code; tag = "R5 invalid marker";
            end else if (int'(c) < lo) begin
                e = 8'(lo); tag = cfg_narrow ? "R4 low clamp" : "R3 low clamp";
            end else if (int'(c) > hi) begin
                e = 8'(hi); tag = cfg_narrow ? "R4 high clamp" : "R3 high clamp";
            end else begin
                e = c; tag = "R2 R12 component order";
            end
            return;
        end
        en = q;
        while (en < slen && !a_act[en]) en++;
        if (cfg_656 && st > 0 && k < 4) begin
            e = (k == 0) ? 8'hFF : (k == 3) ? xy(a_f[st-1], a_v[st-1], 1'b1) : 8'h00;
            tag = (k == 3) ? (cfg_alt_task ? "R7 R9 R10 end word" : "R7 R9 end word") : "R7 end preamble";
            return;
        end
        if (cfg_656 && en < slen && (en - q) <= 4) begin
            int w = 4 - (en - q);
            e = (w == 0) ? 8'hFF : (w == 3) ? xy(a_f[en], a_v[en], 1'b0) : 8'h00;
            tag = (w == 3) ? (cfg_alt_task ? "R8 R9 R10 start word" : "R8 R9 start word") : "R8 start preamble";
            return;
        end
        case (k % 4)
            0:       e = cfg_fill_u;
            2:       e = cfg_fill_v;
            default: e = cfg_fill_y;
        endcase
        tag = cfg_656 ? "R6 fill" : "R11 R6 fill without codes";
    endtask

    task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic drive(input int idx);
        if (idx < slen) begin
            in_act = a_act[idx]; in_ok = a_ok[idx]; in_field = a_f[idx];
            in_vblank = a_v[idx]; in_y = a_y[idx]; in_cb = a_cb[idx]; in_cr = a_cr[idx];
        end else begin
            in_act = 0; in_ok = 0; in_field = 0; in_vblank = 0;
            in_y = 0; in_cb = 0; in_cr = 0;
        end
    endtask

    task automatic run(input bit c656, input bit narrow, input bit alt,
                       input int nlines, input bit directed);
        logic [7:0] e;
        string tag;
        @(negedge clk);
        rst = 1'b1;
        cfg_656 = c656; cfg_narrow = narrow; cfg_alt_task = alt;
        cfg_fill_y = 8'(16 + $urandom % 225);
        cfg_fill_u = 8'(16 + $urandom % 225);
        cfg_fill_v = 8'(16 + $urandom % 225);
        cfg_valid_code = 8'(16 + $urandom % 225);
        slen = 0;
        drive(0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_byte, 8'h00, "R1 reset value");
        build(nlines, directed);
        rst = 1'b0;
        drive(4);
        for (int p = 0; p < slen; p++) begin
            @(posedge clk);
            @(negedge clk);
            calc(p, e, tag);
            if (p == 0) tag = "R1 first fill after reset";
            check(out_byte, e, tag);
            drive(p + 5);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        void'($urandom(32'd6560));
        run(1, 0, 0, 8, 1);   // wide range, shortest line and blanking
        run(1, 1, 0, 8, 0);   // narrow range
        run(1, 0, 1, 10, 0);  // alternate code set on VBI lines
        run(0, 1, 0, 8, 0);   // embedded codes disabled
        run(1, 1, 1, 10, 1);  // narrow plus alternate codes
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

endmodule